// File: doc/BRIEF.md
# Receiver Configuration-Bit Bracketing Sequencer

This block guards receiver reset and receiver line-rate changes on a serial transceiver channel. These events require one bit of a channel configuration register to be low while the channel is being reset. That bit must return to its earlier value afterwards. The block reaches the register only through a dynamic reconfiguration port (DRP), which works as a request/ready handshake.

Either event starts the same sequence:

1. Read the register.
2. Keep the word that was read.
3. Write the word back with the one bit forced low.
4. Pulse the channel reset, applying any new rate at the moment the reset starts.
5. Wait for the channel to report reset-done.
6. Write the kept word back, which puts the bit back to what it was.

A rate change is detected by comparing the requested rate against the rate last applied. A reset request that arrives while a sequence is running is held and served as a second sequence afterwards. A DRP access that receives no ready within a timeout abandons the sequence and raises a sticky error flag.

Top module: `rxcfg_bracket_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `chan_rst`, `drp_en`, `seq_done` and `drp_err` are 0 and `chan_rate` is 0.
- R2: Every DRP access uses address `CFG_ADDR` (default 0x011). `drp_en` is high for exactly one cycle per access. No new access starts before `drp_rdy` has answered the previous one, unless that access timed out.
- R3: A one-cycle pulse on `rst_req` while idle starts a sequence. The sequence is a read (`drp_we`=0) followed by a write (`drp_we`=1) of the word that was read, with bit `CFG_BIT` (default 11) forced to 0 and all other bits unchanged.
- R4: `chan_rst` rises on the cycle after `drp_rdy` answers the clearing write. It stays high for exactly `HOLD_CYC` cycles. The register bit is 0 for the whole time `chan_rst` is high.
- R5: After `chan_rst` falls, the block waits for `chan_done`=1. It then writes back exactly the word it read, so bit 11 returns to its previous value, whether that was 0 or 1.
- R6: `seq_done` is a single-cycle pulse, issued once per completed sequence on the cycle after `drp_rdy` answers the restoring write.
- R7: While idle, a `rate_sel` that differs from `chan_rate` starts the same sequence. `chan_rate` takes the new value on the cycle `chan_rst` rises, and changes at no other time.
- R8: A `rst_req` pulse and a `rate_sel` change in the same cycle run one sequence only: one `chan_rst` pulse, one `seq_done`, three DRP accesses. That sequence applies the new rate.
- R9: A `rst_req` pulse that arrives while a sequence is running is remembered. One further complete sequence follows the current one, and no more than one.
- R10: If `drp_rdy` does not answer an access within `TIMEOUT` cycles, `drp_err` rises and stays high until `rst_n` falls. The sequence is abandoned with `chan_rst` low and no `seq_done`, and later sequences still run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | One-cycle request to reset the receiver |
| rate_sel | input | RATE_W | Requested receiver rate setting |
| drp_en | output | 1 | DRP access strobe, one cycle |
| drp_we | output | 1 | DRP write enable, valid with `drp_en` |
| drp_addr | output | ADDR_W | DRP address |
| drp_wdata | output | DATA_W | DRP write data |
| drp_rdata | input | DATA_W | DRP read data, valid with `drp_rdy` |
| drp_rdy | input | 1 | DRP access completion |
| chan_rst | output | 1 | Reset toward the channel |
| chan_rate | output | RATE_W | Rate setting applied to the channel |
| chan_done | input | 1 | Channel reports reset complete |
| seq_done | output | 1 | Sequence complete pulse |
| drp_err | output | 1 | Sticky DRP timeout flag |

## Verification
Two things can arrive in the same cycle: a reset request, and a rate request (a `rate_sel` value different from the applied rate). The bench drives both on one edge and expects them to merge into a single sequence. It judges this by counting `chan_rst` pulses, `seq_done` pulses and DRP accesses, and by checking that the new rate appears on `chan_rate` at the single reset rise. A second overlap, a reset request landing in the middle of a running sequence, is provoked a few cycles after a first request. It is judged by exactly two complete sequences and no third.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_READ,
      SQ_CLEAR,
      SQ_HOLD,
      SQ_SETTLE,
      SQ_RESTORE
   } seq_state_t;
endpackage

// File: rtl/rxcfg_drp_port.sv
module rxcfg_drp_port #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h011,
   parameter int TIMEOUT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_go,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              acc_ack,
   output logic              acc_tmo,
   output logic              drp_en,
   output logic              drp_we,
   output logic [ADDR_W-1:0] drp_addr,
   output logic [DATA_W-1:0] drp_wdata,
   input  logic              drp_rdy
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);

   logic             busy_q;
   logic [CNT_W-1:0] age_q;

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("rxcfg_drp_port: TIMEOUT must be at least 2");
   end

   assign drp_addr = CFG_ADDR;
   assign acc_ack  = busy_q & drp_rdy;
   assign acc_tmo  = busy_q & ~drp_rdy & (age_q == CNT_W'(TIMEOUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drp_en    <= 1'b0;
         drp_we    <= 1'b0;
         drp_wdata <= '0;
         busy_q    <= 1'b0;
         age_q     <= '0;
      end else begin
         drp_en <= acc_go;
         drp_we <= acc_go & acc_we;
         if (acc_go) begin
            drp_wdata <= acc_wdata;
            busy_q    <= 1'b1;
            age_q     <= '0;
         end else if (acc_ack || acc_tmo) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            age_q <= age_q + 1'b1;
         end
      end
   end

   // R2
   one_shot_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drp_en |=> !drp_en);

   // R2
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_go |-> (!busy_q || acc_ack || acc_tmo));
endmodule

// File: rtl/rxcfg_bracket_fsm.sv
module rxcfg_bracket_fsm
   import rxcfg_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int RATE_W   = 3,
   parameter int CFG_BIT  = 11,
   parameter int HOLD_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic              chan_done,
   input  logic              acc_ack,
   input  logic              acc_tmo,
   input  logic [DATA_W-1:0] rdata,
   output logic              acc_go,
   output logic              acc_we,
   output logic [DATA_W-1:0] acc_wdata,
   output logic              chan_rst,
   output logic [RATE_W-1:0] chan_rate,
   output logic              seq_done,
   output logic              drp_err
);
   localparam int HC_W = $clog2(HOLD_CYC + 1);
   localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << CFG_BIT);

   seq_state_t        st_q;
   logic [DATA_W-1:0] saved_q;
   logic [RATE_W-1:0] tgt_q;
   logic              pend_q;
   logic [HC_W-1:0]   hold_q;
   logic              start;

   assign start = (st_q == SQ_IDLE) && (rst_req || pend_q || (rate_sel != chan_rate));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         saved_q   <= '0;
         tgt_q     <= '0;
         pend_q    <= 1'b0;
         hold_q    <= '0;
         acc_go    <= 1'b0;
         acc_we    <= 1'b0;
         acc_wdata <= '0;
         chan_rst  <= 1'b0;
         chan_rate <= '0;
         seq_done  <= 1'b0;
         drp_err   <= 1'b0;
      end else begin
         acc_go   <= 1'b0;
         acc_we   <= 1'b0;
         seq_done <= 1'b0;
         if (rst_req && (st_q != SQ_IDLE)) pend_q <= 1'b1;
         case (st_q)
            SQ_IDLE: if (start) begin
               acc_go <= 1'b1;
               tgt_q  <= rate_sel;
               pend_q <= 1'b0;
               st_q   <= SQ_READ;
            end
            SQ_READ: if (acc_ack) begin
               saved_q   <= rdata;
               acc_go    <= 1'b1;
               acc_we    <= 1'b1;
               acc_wdata <= rdata & KEEP_MASK;
               st_q      <= SQ_CLEAR;
            end else if (acc_tmo) begin
               drp_err <= 1'b1;
               st_q    <= SQ_IDLE;
            end
            SQ_CLEAR: if (acc_ack) begin
               chan_rst  <= 1'b1;
               chan_rate <= tgt_q;
               hold_q    <= '0;
               st_q      <= SQ_HOLD;
            end else if (acc_tmo) begin
               drp_err <= 1'b1;
               st_q    <= SQ_IDLE;
            end
            SQ_HOLD: if (hold_q == HC_W'(HOLD_CYC - 1)) begin
               chan_rst <= 1'b0;
               st_q     <= SQ_SETTLE;
            end else begin
               hold_q <= hold_q + 1'b1;
            end
            SQ_SETTLE: if (chan_done) begin
               acc_go    <= 1'b1;
               acc_we    <= 1'b1;
               acc_wdata <= saved_q;
               st_q      <= SQ_RESTORE;
            end
            SQ_RESTORE: if (acc_ack) begin
               seq_done <= 1'b1;
               st_q     <= SQ_IDLE;
            end else if (acc_tmo) begin
               drp_err <= 1'b1;
               st_q    <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // R4
   clear_before_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_rst) |-> $past(acc_ack));

   // R7
   rate_under_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(chan_rst) |-> $stable(chan_rate));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drp_err |=> drp_err);
endmodule

// File: rtl/rxcfg_bracket_seq.sv
module rxcfg_bracket_seq #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] CFG_ADDR = 9'h011,
   parameter int CFG_BIT  = 11,
   parameter int RATE_W   = 3,
   parameter int TIMEOUT  = 64,
   parameter int HOLD_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rst_req,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              drp_en,
   output logic              drp_we,
   output logic [ADDR_W-1:0] drp_addr,
   output logic [DATA_W-1:0] drp_wdata,
   input  logic [DATA_W-1:0] drp_rdata,
   input  logic              drp_rdy,
   output logic              chan_rst,
   output logic [RATE_W-1:0] chan_rate,
   input  logic              chan_done,
   output logic              seq_done,
   output logic              drp_err
);
   logic              acc_go, acc_we, acc_ack, acc_tmo;
   logic [DATA_W-1:0] acc_wdata;

   if (CFG_BIT >= DATA_W) begin : g_bad_bit
      $error("rxcfg_bracket_seq: CFG_BIT outside the data word");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("rxcfg_bracket_seq: HOLD_CYC must be at least 1");
   end

   rxcfg_drp_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_ADDR(CFG_ADDR), .TIMEOUT(TIMEOUT)
   ) u_port (
      .clk(clk), .rst_n(rst_n),
      .acc_go(acc_go), .acc_we(acc_we), .acc_wdata(acc_wdata),
      .acc_ack(acc_ack), .acc_tmo(acc_tmo),
      .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
      .drp_wdata(drp_wdata), .drp_rdy(drp_rdy)
   );

   rxcfg_bracket_fsm #(
      .DATA_W(DATA_W), .RATE_W(RATE_W), .CFG_BIT(CFG_BIT), .HOLD_CYC(HOLD_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .rst_req(rst_req), .rate_sel(rate_sel), .chan_done(chan_done),
      .acc_ack(acc_ack), .acc_tmo(acc_tmo), .rdata(drp_rdata),
      .acc_go(acc_go), .acc_we(acc_we), .acc_wdata(acc_wdata),
      .chan_rst(chan_rst), .chan_rate(chan_rate),
      .seq_done(seq_done), .drp_err(drp_err)
   );
endmodule

// File: tb/sim_rxcfg_bracket_seq.sv
module sim_rxcfg_bracket_seq;
   localparam int CLK_NS   = 10;
   localparam int TMO      = 32;
   localparam int HOLD     = 4;
   localparam int DONE_LAT = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_req = 1'b0;
   logic [2:0]  rate_sel = 3'd0;
   logic        drp_en, drp_we, chan_rst, seq_done, drp_err;
   logic [8:0]  drp_addr;
   logic [15:0] drp_wdata;
   logic [15:0] drp_rdata = 16'h0;
   logic        drp_rdy = 1'b0;
   logic [2:0]  chan_rate;
   logic        chan_done = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_NS/2) clk = ~clk;

   rxcfg_bracket_seq #(.TIMEOUT(TMO), .HOLD_CYC(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rate_sel(rate_sel),
      .drp_en(drp_en), .drp_we(drp_we), .drp_addr(drp_addr),
      .drp_wdata(drp_wdata), .drp_rdata(drp_rdata), .drp_rdy(drp_rdy),
      .chan_rst(chan_rst), .chan_rate(chan_rate), .chan_done(chan_done),
      .seq_done(seq_done), .drp_err(drp_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural DRP register stub
   logic [15:0] cfg_word = 16'h0;
   bit          ld = 1'b0;
   logic [15:0] ld_val = 16'h0;
   bit          mute = 1'b0;
   logic        st_pend = 1'b0;
   int          st_cnt = 0;
   logic        st_we = 1'b0;
   logic [15:0] st_dat = 16'h0;
   always @(posedge clk) begin
      drp_rdy <= 1'b0;
      if (ld) cfg_word <= ld_val;
      if (drp_en) begin
         if (!mute) begin
            st_pend <= 1'b1; st_cnt <= 2; st_we <= drp_we; st_dat <= drp_wdata;
         end
      end else if (st_pend) begin
         if (st_cnt == 0) begin
            drp_rdy   <= 1'b1;
            drp_rdata <= cfg_word;
            if (st_we) cfg_word <= st_dat;
            st_pend <= 1'b0;
         end else begin
            st_cnt <= st_cnt - 1;
         end
      end
   end

   // behavioural channel stub
   int dcnt = 0;
   always @(posedge clk) begin
      if (chan_rst) begin
         chan_done <= 1'b0; dcnt <= 0;
      end else if (!chan_done) begin
         if (dcnt == DONE_LAT) chan_done <= 1'b1;
         else dcnt <= dcnt + 1;
      end
   end

   // reference model: access log, pulse counts, per-cycle rules
   logic [16:0] acc_q[$];
   bit       out_q = 0;
   int       out_age = 0;
   bit       prst = 0;
   bit       pdone = 0;
   logic [2:0] prate = 3'd0;
   int       hlen = 0;
   int       rst_pulses = 0;
   int       done_cnt = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         out_q = 0; prst = 0; pdone = 0; prate = 3'd0; hlen = 0;
      end else begin
         if (drp_rdy) out_q = 0;
         if (out_q) begin
            out_age++;
            if (out_age > TMO) out_q = 0;
         end
         if (drp_en) begin
            check(drp_addr == 9'h011, "R2", "access address", drp_addr, 9'h011);
            check(!out_q, "R2", "access while previous outstanding", out_q, 0);
            out_q = 1; out_age = 0;
            acc_q.push_back({drp_we, drp_we ? drp_wdata : 16'h0});
         end
         if (chan_rst)
            check(cfg_word[11] == 1'b0, "R4", "config bit during channel reset", cfg_word[11], 0);
         if (chan_rate != prate)
            check(chan_rst && !prst, "R7", "rate changed outside reset rise", chan_rate, prate);
         if (chan_rst && !prst) begin rst_pulses++; hlen = 0; end
         if (chan_rst) hlen++;
         if (!chan_rst && prst)
            check(hlen == HOLD, "R4", "channel reset length", hlen, HOLD);
         if (seq_done) begin
            done_cnt++;
            check(!pdone, "R6", "done pulse longer than one cycle", 2, 1);
         end
         prst = chan_rst; prate = chan_rate; pdone = seq_done;
      end
   end

   task automatic load(input logic [15:0] w);
      @(negedge clk); ld_val = w; ld = 1'b1;
      @(negedge clk); ld = 1'b0;
   endtask

   task automatic pulse_req();
      @(negedge clk); rst_req = 1'b1;
      @(negedge clk); rst_req = 1'b0;
   endtask

   task automatic wait_done(input int target);
      for (int i = 0; i < 2000 && done_cnt < target; i++) @(negedge clk);
   endtask

   task automatic check_seq(input string tag, input logic [15:0] orig, input logic [15:0] clr);
      check(acc_q.size() == 3, tag, "access count", acc_q.size(), 3);
      if (acc_q.size() == 3) begin
         check(acc_q[0] == 17'h0, "R3", "first access is a read", acc_q[0], 0);
         check(acc_q[1] == {1'b1, clr}, "R3", "clearing write", acc_q[1], {1'b1, clr});
         check(acc_q[2] == {1'b1, orig}, "R5", "restoring write", acc_q[2], {1'b1, orig});
      end
      check(cfg_word == orig, "R5", "register after sequence", cfg_word, orig);
   endtask

   initial begin
      int bp, bd;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(!chan_rst && !drp_en && !seq_done && !drp_err, "R1", "outputs in reset",
            {chan_rst, drp_en, seq_done, drp_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!chan_rst && !drp_en && !seq_done && !drp_err, "R1", "outputs after reset",
            {chan_rst, drp_en, seq_done, drp_err}, 0);
      check(chan_rate == 3'd0, "R1", "rate after reset", chan_rate, 0);
      repeat (DONE_LAT + 4) @(negedge clk);

      // R3 R4 R5 R6: bit 11 set
      load(16'h5A3C); acc_q.delete(); bp = rst_pulses; bd = done_cnt;
      pulse_req(); wait_done(bd + 1); repeat (5) @(negedge clk);
      check_seq("R3", 16'h5A3C, 16'h523C);
      check(rst_pulses == bp + 1, "R4", "reset pulses", rst_pulses - bp, 1);
      check(done_cnt == bd + 1, "R6", "done pulses", done_cnt - bd, 1);

      // R5: bit 11 already clear
      load(16'h2481); acc_q.delete(); bd = done_cnt;
      pulse_req(); wait_done(bd + 1); repeat (5) @(negedge clk);
      check_seq("R5", 16'h2481, 16'h2481);

      // R7: rate change alone
      load(16'hFFFF); acc_q.delete(); bp = rst_pulses; bd = done_cnt;
      @(negedge clk); rate_sel = 3'd3;
      wait_done(bd + 1); repeat (20) @(negedge clk);
      check_seq("R7", 16'hFFFF, 16'hF7FF);
      check(chan_rate == 3'd3, "R7", "applied rate", chan_rate, 3);
      check(rst_pulses == bp + 1, "R7", "reset pulses", rst_pulses - bp, 1);

      // R8: reset request and rate change in the same cycle
      load(16'h0F0F); acc_q.delete(); bp = rst_pulses; bd = done_cnt;
      @(negedge clk); rate_sel = 3'd5; rst_req = 1'b1;
      @(negedge clk); rst_req = 1'b0;
      wait_done(bd + 1); repeat (30) @(negedge clk);
      check_seq("R8", 16'h0F0F, 16'h070F);
      check(rst_pulses == bp + 1, "R8", "single reset pulse", rst_pulses - bp, 1);
      check(done_cnt == bd + 1, "R8", "single done", done_cnt - bd, 1);
      check(chan_rate == 3'd5, "R8", "applied rate", chan_rate, 5);

      // R9: request during a running sequence
      load(16'h0800); acc_q.delete(); bp = rst_pulses; bd = done_cnt;
      pulse_req(); repeat (3) @(negedge clk); pulse_req();
      wait_done(bd + 2); repeat (30) @(negedge clk);
      check(done_cnt == bd + 2, "R9", "done pulses", done_cnt - bd, 2);
      check(rst_pulses == bp + 2, "R9", "reset pulses", rst_pulses - bp, 2);
      check(acc_q.size() == 6, "R9", "access count", acc_q.size(), 6);
      check(cfg_word == 16'h0800, "R9", "register after both", cfg_word, 16'h0800);

      // R10: ready never arrives
      mute = 1'b1; bp = rst_pulses; bd = done_cnt;
      pulse_req(); repeat (TMO/2) @(negedge clk);
      check(!drp_err, "R10", "error before timeout", drp_err, 0);
      repeat (TMO + 5) @(negedge clk);
      check(drp_err, "R10", "error after timeout", drp_err, 1);
      check(!chan_rst, "R10", "channel reset after abandon", chan_rst, 0);
      check(done_cnt == bd && rst_pulses == bp, "R10", "no done or reset after abandon",
            done_cnt - bd, 0);
      mute = 1'b0;
      load(16'h0800); acc_q.delete(); bd = done_cnt;
      pulse_req(); wait_done(bd + 1); repeat (5) @(negedge clk);
      check_seq("R10", 16'h0800, 16'h0000);
      check(drp_err, "R10", "error stays high", drp_err, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL all watchdog expired: actual %0h expected %0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule